// File: doc/BRIEF.md
# CAN Test-Mode Path Controller

This block sits between a CAN protocol engine and the transceiver pins and applies the node's self-test and listen-only behaviour. It has three operating modes. In normal mode it passes bits straight through. In loopback-silent mode every bit the engine sends comes back to the engine's receive input. The physical transmit pin is held recessive and the physical receive pin is ignored. During the acknowledge slot the receiver is shown a dominant bit, so a node can receive its own frame without another station on the bus. In monitor mode the node listens only: it never drives a dominant level, and its error counters do not move.

The block also keeps the transmit and receive error counters. From them it derives the two-bit error state that software reads. In monitor mode that field is forced to error-passive. The block gates the transmit-complete and receive-complete interrupts by mode. In monitor mode a frame that nobody acknowledged raises a bit-dominant error flag instead of a receive interrupt. The mode request is taken only while the engine reports that it is idle between frames.

Top module: `can_testmode_ctl`

## Requirements
- R1: In loopback-silent mode (`active_mode` = 2'b01), `eng_rx_bit` equals `eng_tx_bit` whenever `eng_ack_slot` is low.
- R2: In loopback-silent mode, `pin_tx` is 1 (recessive) and the value on `pin_rx` has no effect on `eng_rx_bit`.
- R3: In loopback-silent mode, `eng_rx_bit` is 0 (dominant) while `eng_ack_slot` is high, whatever `eng_tx_bit` is.
- R4: In loopback-silent mode and in normal mode, a `tx_done` strobe gives a one-cycle `irq_tx` pulse in the following cycle. A `rx_done` strobe likewise gives a one-cycle `irq_rx` pulse.
- R5: In monitor mode (`active_mode` = 2'b10), `err_state` reads 2'b01 (error passive), whatever the counter values are.
- R6: In monitor mode, the strobes `tx_err`, `tx_ok`, `rx_err` and `rx_ok` leave `tec` and `rec` unchanged.
- R7: In monitor mode, `pin_tx` is 1, `eng_rx_bit` follows `pin_rx`, and `tx_done` raises no `irq_tx`.
- R8: In monitor mode, a `rx_done` strobe with `rx_acked` low gives a one-cycle `bit_dom_err` pulse in the next cycle and no `irq_rx`. With `rx_acked` high it gives `irq_rx` and no `bit_dom_err`.
- R9: The two mode requests are mutually exclusive. When both are set, loopback-silent mode (2'b01) is chosen, and `active_mode` never reads 2'b11.
- R10: `active_mode` takes the requested mode at a clock edge where `eng_idle` is high. While `eng_idle` is low it holds its value.
- R11: Outside monitor mode, `err_state` is derived from the live counters:
  - 2'b10 (bus-off) when `tec` >= 256;
  - otherwise 2'b01 when either counter is >= 128;
  - otherwise 2'b00.
- R12: `tx_err` adds 8 to `tec` and `rx_err` adds 1 to `rec`. The matching `_ok` strobe subtracts 1. An increment strobe wins over a decrement strobe given in the same cycle. Both counters saturate at 0 and at 511.
- R13: After reset, `active_mode` is 2'b00 (normal), both counters are 0 and all interrupt outputs are 0. In normal mode `pin_tx` equals `eng_tx_bit` and `eng_rx_bit` equals `pin_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_loopsil | input | 1 | Mode register: loopback-silent request |
| req_monitor | input | 1 | Mode register: monitor request |
| eng_idle | input | 1 | Engine is idle between frames |
| eng_tx_bit | input | 1 | Bit the engine wants to send |
| eng_ack_slot | input | 1 | Engine is in the acknowledge slot |
| eng_rx_bit | output | 1 | Bit presented to the engine's receiver |
| pin_tx | output | 1 | Transceiver transmit pin |
| pin_rx | input | 1 | Transceiver receive pin |
| tx_err | input | 1 | Transmit error strobe |
| tx_ok | input | 1 | Transmit success strobe |
| rx_err | input | 1 | Receive error strobe |
| rx_ok | input | 1 | Receive success strobe |
| tx_done | input | 1 | Transmit frame complete strobe |
| rx_done | input | 1 | Receive frame complete strobe |
| rx_acked | input | 1 | Completed frame saw an acknowledge |
| irq_tx | output | 1 | Transmit-complete interrupt pulse |
| irq_rx | output | 1 | Receive-complete interrupt pulse |
| bit_dom_err | output | 1 | Bit-dominant error pulse for an unacknowledged frame |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| err_state | output | 2 | Error state seen by software |
| active_mode | output | 2 | Mode in effect |

## Verification
The hardest cases to reach are the counter thresholds and the monitor-mode override. The 256 bus-off and 511 saturation points need long runs of error strobes: the bench drives 32, then 72 `tx_err` pulses, and then counts back down past 255 and 127 to zero. Only after that does it enter monitor mode, so that the forced error-passive value and the frozen counters can be told apart from the live state. The bench also holds `eng_idle` low while it changes the mode request, which shows that the mode holds during a frame.

// File: rtl/can_tm_pkg.sv
package can_tm_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_LOOPSIL = 2'b01,
        MODE_MONITOR = 2'b10
    } tm_mode_e;

    typedef enum logic [1:0] {
        ERR_ACTIVE  = 2'b00,
        ERR_PASSIVE = 2'b01,
        ERR_BUSOFF  = 2'b10
    } err_state_e;

    typedef struct packed {
        logic inc;
        logic dec;
    } cnt_upd_t;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic rx_acked;
    } frame_evt_t;

    // Loopback-silent wins when both requests are present.
    function automatic tm_mode_e pick_mode(input logic ls, input logic mon);
        if (ls)       return MODE_LOOPSIL;
        else if (mon) return MODE_MONITOR;
        else          return MODE_NORMAL;
    endfunction

endpackage

// File: rtl/tm_mode_sel.sv
module tm_mode_sel
    import can_tm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_loopsil,
    input  logic     req_monitor,
    input  logic     eng_idle,
    output tm_mode_e mode
);
    tm_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)           mode_q <= MODE_NORMAL;
        else if (eng_idle) mode_q <= pick_mode(req_loopsil, req_monitor);
    end

    assign mode = mode_q;
endmodule

// File: rtl/tm_bit_path.sv
module tm_bit_path
    import can_tm_pkg::*;
(
    input  tm_mode_e mode,
    input  logic     eng_tx_bit,
    input  logic     eng_ack_slot,
    input  logic     pin_rx,
    output logic     eng_rx_bit,
    output logic     pin_tx
);
    always_comb begin
        unique case (mode)
            MODE_LOOPSIL: begin
                pin_tx     = 1'b1;
                // The engine's own ACK slot reads dominant, so the self-sent frame is accepted.
                eng_rx_bit = eng_ack_slot ? 1'b0 : eng_tx_bit;
            end
            MODE_MONITOR: begin
                pin_tx     = 1'b1;
                eng_rx_bit = pin_rx;
            end
            default: begin
                pin_tx     = eng_tx_bit;
                eng_rx_bit = pin_rx;
            end
        endcase
    end
endmodule

// File: rtl/tm_err_cnt.sv
module tm_err_cnt
    import can_tm_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int INC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  cnt_upd_t         upd,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0]   STEP_X = (CNT_W+1)'(INC_STEP);
    localparam logic [CNT_W:0]   MAX_X  = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    assign sum = {1'b0, cnt_q} + STEP_X;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!freeze) begin
            if (upd.inc)
                cnt_q <= (sum > MAX_X) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
            else if (upd.dec && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tm_irq_gate.sv
module tm_irq_gate
    import can_tm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tm_mode_e   mode,
    input  frame_evt_t evt,
    output logic       irq_tx,
    output logic       irq_rx,
    output logic       bit_dom_err
);
    logic mon;
    assign mon = (mode == MODE_MONITOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_tx      <= 1'b0;
            irq_rx      <= 1'b0;
            bit_dom_err <= 1'b0;
        end else begin
            irq_tx      <= evt.tx_done && !mon;
            irq_rx      <= evt.rx_done && (!mon || evt.rx_acked);
            bit_dom_err <= evt.rx_done && mon && !evt.rx_acked;
        end
    end
endmodule

// File: rtl/can_testmode_ctl.sv
module can_testmode_ctl
    import can_tm_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int TX_ERR_STEP = 8,
    parameter int RX_ERR_STEP = 1,
    parameter int PASSIVE_LIM = 128,
    parameter int BUSOFF_LIM  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_loopsil,
    input  logic             req_monitor,
    input  logic             eng_idle,
    input  logic             eng_tx_bit,
    input  logic             eng_ack_slot,
    output logic             eng_rx_bit,
    output logic             pin_tx,
    input  logic             pin_rx,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             rx_err,
    input  logic             rx_ok,
    input  logic             tx_done,
    input  logic             rx_done,
    input  logic             rx_acked,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             bit_dom_err,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic [1:0]       err_state,
    output logic [1:0]       active_mode
);
    localparam int NUM_CNT = 2;
    localparam logic [CNT_W-1:0] PAS_L = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] BOF_L = CNT_W'(BUSOFF_LIM);

    tm_mode_e   mode;
    cnt_upd_t   upd   [NUM_CNT];
    logic [CNT_W-1:0] cnt_v [NUM_CNT];
    frame_evt_t evt;
    logic       freeze;

    tm_mode_sel u_mode (
        .clk(clk), .rst(rst),
        .req_loopsil(req_loopsil), .req_monitor(req_monitor),
        .eng_idle(eng_idle), .mode(mode)
    );

    tm_bit_path u_path (
        .mode(mode), .eng_tx_bit(eng_tx_bit), .eng_ack_slot(eng_ack_slot),
        .pin_rx(pin_rx), .eng_rx_bit(eng_rx_bit), .pin_tx(pin_tx)
    );

    assign freeze = (mode == MODE_MONITOR);
    assign upd[0] = '{inc: tx_err, dec: tx_ok};
    assign upd[1] = '{inc: rx_err, dec: rx_ok};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        tm_err_cnt #(
            .CNT_W(CNT_W),
            .INC_STEP((g == 0) ? TX_ERR_STEP : RX_ERR_STEP)
        ) u_cnt (
            .clk(clk), .rst(rst), .freeze(freeze),
            .upd(upd[g]), .cnt(cnt_v[g])
        );
    end

    assign tec = cnt_v[0];
    assign rec = cnt_v[1];

    assign evt = '{tx_done: tx_done, rx_done: rx_done, rx_acked: rx_acked};

    tm_irq_gate u_irq (
        .clk(clk), .rst(rst), .mode(mode), .evt(evt),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .bit_dom_err(bit_dom_err)
    );

    err_state_e st;
    always_comb begin
        if (mode == MODE_MONITOR)                st = ERR_PASSIVE;
        else if (tec >= BOF_L)                   st = ERR_BUSOFF;
        else if (tec >= PAS_L || rec >= PAS_L)   st = ERR_PASSIVE;
        else                                     st = ERR_ACTIVE;
    end

    assign err_state   = st;
    assign active_mode = mode;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             eng_idle,
    input logic             eng_tx_bit,
    input logic             eng_ack_slot,
    input logic             eng_rx_bit,
    input logic             pin_tx,
    input logic             rx_done,
    input logic             rx_acked,
    input logic             irq_rx,
    input logic             bit_dom_err,
    input logic [CNT_W-1:0] tec,
    input logic [CNT_W-1:0] rec,
    input logic [1:0]       err_state,
    input logic [1:0]       active_mode
);
    AST_LS_LOOP: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b01 && !eng_ack_slot) |-> eng_rx_bit == eng_tx_bit); // R1
    AST_LS_TX_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b01) |-> pin_tx); // R2
    AST_LS_ACK_DOMINANT: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b01 && eng_ack_slot) |-> !eng_rx_bit); // R3
    AST_MON_PASSIVE: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b10) |-> err_state == 2'b01); // R5
    AST_MON_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b10) |=> (tec == $past(tec) && rec == $past(rec))); // R6
    AST_MON_NO_DOMINANT: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b10) |-> pin_tx); // R7
    AST_MON_UNACKED: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b10 && rx_done && !rx_acked) |=> (bit_dom_err && !irq_rx)); // R8
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        active_mode != 2'b11); // R9
    AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !eng_idle |=> $stable(active_mode)); // R10
endmodule

bind can_testmode_ctl tm_checker #(.CNT_W(CNT_W)) u_tm_checker (
    .clk(clk), .rst(rst), .eng_idle(eng_idle), .eng_tx_bit(eng_tx_bit),
    .eng_ack_slot(eng_ack_slot), .eng_rx_bit(eng_rx_bit), .pin_tx(pin_tx),
    .rx_done(rx_done), .rx_acked(rx_acked), .irq_rx(irq_rx),
    .bit_dom_err(bit_dom_err), .tec(tec), .rec(rec),
    .err_state(err_state), .active_mode(active_mode)
);

// File: tb/test_can_testmode_ctl.sv
module test_can_testmode_ctl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_loopsil = 0, req_monitor = 0, eng_idle = 1;
    logic eng_tx_bit = 1, eng_ack_slot = 0, pin_rx = 1;
    logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0;
    logic tx_done = 0, rx_done = 0, rx_acked = 0;
    logic eng_rx_bit, pin_tx, irq_tx, irq_rx, bit_dom_err;
    logic [8:0] tec, rec;
    logic [1:0] err_state, active_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    can_testmode_ctl i_can_testmode_ctl (
        .clk(clk), .rst(rst), .req_loopsil(req_loopsil), .req_monitor(req_monitor),
        .eng_idle(eng_idle), .eng_tx_bit(eng_tx_bit), .eng_ack_slot(eng_ack_slot),
        .eng_rx_bit(eng_rx_bit), .pin_tx(pin_tx), .pin_rx(pin_rx),
        .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err), .rx_ok(rx_ok),
        .tx_done(tx_done), .rx_done(rx_done), .rx_acked(rx_acked),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .bit_dom_err(bit_dom_err),
        .tec(tec), .rec(rec), .err_state(err_state), .active_mode(active_mode)
    );

    // {req_ls, req_mon, tx_bit, pin_rx, ack_slot, exp_mode[1:0], exp_pin_tx, exp_rx_bit}
    localparam logic [8:0] VEC [10] = '{
        9'b0_0_0_1_0_00_0_1,   // R13 normal pass-through
        9'b0_0_1_0_0_00_1_0,   // R13
        9'b0_0_0_0_1_00_0_0,   // R13 ack slot no effect
        9'b1_0_1_0_0_01_1_1,   // R1 R2 loop of a 1, pin ignored
        9'b1_0_0_1_0_01_1_0,   // R1 R2 loop of a 0, pin ignored
        9'b1_0_1_1_1_01_1_0,   // R3 forced ack
        9'b1_0_0_0_1_01_1_0,   // R3
        9'b0_1_0_1_0_10_1_1,   // R7 monitor from pin
        9'b0_1_0_0_1_10_1_0,   // R7
        9'b1_1_0_1_0_01_1_0    // R9 priority
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_tx_err(input int n);
        for (int i = 0; i < n; i++) begin
            tx_err = 1; tick(); tx_err = 0;
        end
    endtask

    task automatic set_mode(input logic ls, input logic mon);
        req_loopsil = ls; req_monitor = mon; eng_idle = 1;
        tick();
        eng_idle = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 0;
        #1;
        // R13 reset state
        check(active_mode == 2'b00, "R13 mode", active_mode, 0);
        check(tec == 0 && rec == 0, "R13 counters", tec + rec, 0);
        check(!irq_tx && !irq_rx && !bit_dom_err, "R13 irqs", {irq_tx, irq_rx, bit_dom_err}, 0);

        // Table walk
        for (int v = 0; v < 10; v++) begin
            set_mode(VEC[v][8], VEC[v][7]);
            eng_tx_bit = VEC[v][6]; pin_rx = VEC[v][5]; eng_ack_slot = VEC[v][4];
            #1;
            check(active_mode == VEC[v][3:2], "R9/R13 mode", active_mode, VEC[v][3:2]);
            check(pin_tx == VEC[v][1], "R2/R7/R13 pin_tx", pin_tx, VEC[v][1]);
            check(eng_rx_bit == VEC[v][0], "R1/R3/R7 eng_rx_bit", eng_rx_bit, VEC[v][0]);
        end
        eng_ack_slot = 0;

        // R10: request change while busy has no effect
        set_mode(0, 0);
        req_loopsil = 1;
        tick(); tick();
        check(active_mode == 2'b00, "R10 hold while busy", active_mode, 0);
        eng_tx_bit = 0; #1;
        check(pin_tx == 0, "R10 still normal path", pin_tx, 0);
        eng_idle = 1; tick();
        check(active_mode == 2'b01, "R10 take when idle", active_mode, 1);

        // R4: loopback interrupts
        tx_done = 1; rx_done = 1; rx_acked = 0; tick();
        tx_done = 0; rx_done = 0;
        check(irq_tx && irq_rx, "R4 loopback irqs", {irq_tx, irq_rx}, 3);
        tick();
        check(!irq_tx && !irq_rx, "R4 single pulse", {irq_tx, irq_rx}, 0);

        // R12 / R11 counters in normal mode
        set_mode(0, 0);
        pulse_tx_err(16);
        check(tec == 128, "R12 tec step", tec, 128);
        check(err_state == 2'b01, "R11 passive at 128", err_state, 1);
        pulse_tx_err(16);
        check(err_state == 2'b10, "R11 bus-off at 256", err_state, 2);
        tx_ok = 1; tick(); tx_ok = 0;
        check(tec == 255 && err_state == 2'b01, "R11 back to passive", tec, 255);
        pulse_tx_err(40);
        check(tec == 511, "R12 saturate high", tec, 511);
        tx_err = 1; tx_ok = 1; tick(); tx_err = 0; tx_ok = 0;
        check(tec == 511, "R12 inc wins", tec, 511);
        tx_ok = 1;
        for (int i = 0; i < 520; i++) tick();
        tx_ok = 0;
        check(tec == 0 && err_state == 2'b00, "R12 saturate low", tec, 0);
        rx_err = 1; tick(); tick(); tick(); rx_err = 0;
        check(rec == 3, "R12 rec step", rec, 3);
        rx_ok = 1; for (int i = 0; i < 5; i++) tick(); rx_ok = 0;
        check(rec == 0, "R12 rec floor", rec, 0);

        // R5 R6 R7 R8 monitor mode
        set_mode(0, 1);
        check(err_state == 2'b01, "R5 forced passive", err_state, 1);
        tx_err = 1; rx_err = 1; tick(); tick(); tick(); tx_err = 0; rx_err = 0;
        check(tec == 0 && rec == 0, "R6 frozen", tec + rec, 0);
        tx_done = 1; tick(); tx_done = 0;
        check(!irq_tx, "R7 no tx irq", irq_tx, 0);
        rx_done = 1; rx_acked = 0; tick(); rx_done = 0;
        check(bit_dom_err && !irq_rx, "R8 unacked", {bit_dom_err, irq_rx}, 2);
        tick();
        check(!bit_dom_err, "R8 pulse ends", bit_dom_err, 0);
        rx_done = 1; rx_acked = 1; tick(); rx_done = 0; rx_acked = 0;
        check(irq_rx && !bit_dom_err, "R8 acked", {bit_dom_err, irq_rx}, 1);

        // R11 leaving monitor
        set_mode(0, 0);
        check(err_state == 2'b00 && tec == 0, "R11 live state after monitor", err_state, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule